// File: doc/BRIEF.md
# Registered Read-Only Memory with Initialize Word and Selectable Output Enable

This block models a 2048-word by 8-bit read-only memory whose output passes through a pipeline register. The word at the applied address is always present at the input of the register. It reaches the data outputs on the next rising clock edge. Because of this, the address can move on to the next location while the previous word is still being driven, which suits microprogram sequencers that fetch the next word while the current one executes.

An active-low initialize input forces a stored 2049th word onto the outputs at once, without waiting for a clock edge. That word can act as a clear, a preset, or any chosen start pattern. A single active-low enable input gates the output drivers. A one-time configuration cell selects how that enable acts:
- In immediate mode, the enable acts as soon as it changes.
- In clocked mode, it is sampled on rising clock edges.

The stored contents are written through a preload port:
- Each write can only set bits.
- An erase input returns every word, the initialize word and the configuration cell to zero.

Tri-state buffers are modelled by a separate drive-enable bit for each data bit.

Top module: `regprom_pipe`

## Requirements
- R1: After erase, every array word and the initialize word read as 0x00, and the block is in immediate enable mode.
- R2: The data outputs show the word at the address sampled on the most recent rising clock edge. A change of address between edges leaves the outputs unchanged until the next edge.
- R3: A preload write ORs its data into the selected word. Bits can be set but never cleared. The select field is 0 for an array word at progAddr, 1 for the initialize word, and 2 for the clocked-mode configuration cell.
- R4: While initN is low, dataOut equals the initialize word. This takes effect without any clock edge and is held across any clock edges that occur meanwhile.
- R5: After initN returns high, the first rising edge still presents the initialize word. The following edge loads the array word at the address.
- R6: With an unprogrammed initialize word, initialize clears the outputs to 0x00. With an all-ones word, it presets them to 0xFF.
- R7: In immediate mode, dataOe is 0xFF whenever enN is low and 0x00 whenever enN is high, with no clock edge involved.
- R8: In clocked mode, dataOe takes the value 0xFF or 0x00 from enN (low gives 0xFF) on each rising edge. Changes of enN between edges have no effect.
- R9: After power-up reset (rstN low) in clocked mode, dataOe is 0x00 until the first edge that samples enN low.
- R10: Asserting initialize does not change the output drive state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock, rising edge active |
| rstN | input | 1 | Power-up reset of pipeline state, active low, asynchronous |
| eraseN | input | 1 | Erase of all stored contents, active low, asynchronous |
| progEn | input | 1 | Preload write strobe, sampled on rising edge |
| progSel | input | 2 | Preload target: 0 array, 1 initialize word, 2 clocked-mode cell |
| progAddr | input | 11 | Array word address for preload |
| progData | input | 8 | Bits to set in the target word |
| addr | input | 11 | Read address |
| initN | input | 1 | Initialize, active low, asynchronous |
| enN | input | 1 | Output enable, active low |
| dataOut | output | 8 | Registered output data |
| dataOe | output | 8 | Per-bit drive enable (1 = driven) |

## Verification
A stale initialize-pending flag shows up in two ways:
- It leaves the initialize word on dataOut one edge too long.
- It hands the array word over one edge too early.

Either case is visible within two clock edges of initN rising. A wrong clocked-enable flop shows as dataOe differing from enN sampled on the previous edge. In immediate mode, any registering of the enable shows as dataOe lagging a change of enN that was made between edges. Preload faults show as a word losing bits, or failing to read zero after erase, on the first read of that address.

// File: rtl/regprom_pkg.sv
package regprom_pkg;

  typedef enum logic [1:0] {
    PROG_ARRAY = 2'd0,
    PROG_INIT  = 2'd1,
    PROG_SYNC  = 2'd2,
    PROG_NONE  = 2'd3
  } progSel_e;

  typedef struct packed {
    logic loadInitWord;
    logic driveOn;
  } pipeStrobes_t;

endpackage

// File: rtl/prom_store.sv
module prom_store
  import regprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              eraseN,
  input  logic              progEn,
  input  progSel_e          progSel,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [DATA_W-1:0] progData,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] readWord,
  output logic [DATA_W-1:0] initWord,
  output logic              syncMode
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DEPTH-1:0]  written;
  logic              wrArray;

  assign wrArray = progEn && (progSel == PROG_ARRAY);

  // Written flags stand in for an erased array without a clearing loop
  always_ff @(posedge clk or negedge eraseN) begin
    if (!eraseN) begin
      written  <= '0;
      initWord <= '0;
      syncMode <= 1'b0;
    end else if (progEn) begin
      unique case (progSel)
        PROG_ARRAY: written[progAddr] <= 1'b1;
        PROG_INIT:  initWord <= initWord | progData;
        PROG_SYNC:  syncMode <= 1'b1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wrArray)
      cells[progAddr] <= (written[progAddr] ? cells[progAddr] : '0) | progData;
  end

  assign readWord = written[addr] ? cells[addr] : '0;

endmodule

// File: rtl/prom_ctrl.sv
module prom_ctrl
  import regprom_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         initN,
  input  logic         enN,
  input  logic         syncMode,
  output pipeStrobes_t strobes
);
  logic initPend;
  logic syncOn;

  // Set the moment initN falls; cleared by the first edge seen with initN high
  always_ff @(posedge clk or negedge initN or negedge rstN) begin
    if (!rstN)       initPend <= 1'b0;
    else if (!initN) initPend <= 1'b1;
    else             initPend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncOn <= 1'b0;
    else       syncOn <= !enN;
  end

  always_comb begin
    strobes.loadInitWord = initPend;
    strobes.driveOn      = syncMode ? syncOn : !enN;
  end

endmodule

// File: rtl/prom_datapath.sv
module prom_datapath
  import regprom_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pipeStrobes_t      strobes,
  input  logic [DATA_W-1:0] readWord,
  input  logic [DATA_W-1:0] initWord,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] dataOe
);
  logic [DATA_W-1:0] masterWord;
  logic [DATA_W-1:0] slaveWord;

  assign masterWord = strobes.loadInitWord ? initWord : readWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slaveWord <= '0;
    else       slaveWord <= masterWord;
  end

  assign dataOut = strobes.loadInitWord ? initWord : slaveWord;

  for (genvar b = 0; b < DATA_W; b++) begin : g_drv
    assign dataOe[b] = strobes.driveOn;
  end

endmodule

// File: rtl/regprom_pipe.sv
module regprom_pipe
  import regprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eraseN,
  input  logic              progEn,
  input  logic [1:0]        progSel,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [DATA_W-1:0] progData,
  input  logic [ADDR_W-1:0] addr,
  input  logic              initN,
  input  logic              enN,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] dataOe
);
  logic [DATA_W-1:0] readWord;
  logic [DATA_W-1:0] initWord;
  logic              syncMode;
  pipeStrobes_t      strobes;

  prom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uStore (
    .clk(clk), .eraseN(eraseN), .progEn(progEn), .progSel(progSel_e'(progSel)),
    .progAddr(progAddr), .progData(progData), .addr(addr),
    .readWord(readWord), .initWord(initWord), .syncMode(syncMode)
  );

  prom_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .initN(initN), .enN(enN),
    .syncMode(syncMode), .strobes(strobes)
  );

  prom_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .readWord(readWord),
    .initWord(initWord), .dataOut(dataOut), .dataOe(dataOe)
  );

endmodule

// File: rtl/regprom_chk.sv
module regprom_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              eraseN,
  input logic              progEn,
  input logic [1:0]        progSel,
  input logic [DATA_W-1:0] progData,
  input logic              initN,
  input logic              enN,
  input logic              syncMode,
  input logic [DATA_W-1:0] initWord,
  input logic [DATA_W-1:0] dataOut,
  input logic [DATA_W-1:0] dataOe
);
  logic [1:0] edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               edgeCnt <= '0;
    else if (edgeCnt != 2'd2) edgeCnt <= edgeCnt + 2'd1;
  end

  a_r4_init_forces_word: assert property (@(posedge clk) disable iff (!rstN)
    !initN |-> dataOut == initWord);

  a_r5_first_edge_after_release: assert property (@(posedge clk) disable iff (!rstN || !eraseN)
    (edgeCnt == 2'd2 && !$past(initN, 2) && $past(initN)) |-> dataOut == initWord);

  a_r7_async_enable_follows: assert property (@(posedge clk) disable iff (!rstN)
    !syncMode |-> dataOe == {DATA_W{!enN}});

  a_r8_sync_enable_sampled: assert property (@(posedge clk) disable iff (!rstN || !eraseN)
    (edgeCnt != 2'd0 && syncMode && $past(syncMode)) |-> dataOe == {DATA_W{!$past(enN)}});

  a_r3_init_bits_only_set: assert property (@(posedge clk) disable iff (!rstN || !eraseN)
    (edgeCnt != 2'd0 && $past(progEn) && $past(progSel) == 2'd1)
      |-> initWord == ($past(initWord) | $past(progData)));

endmodule

bind regprom_pipe regprom_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .eraseN(eraseN), .progEn(progEn), .progSel(progSel),
  .progData(progData), .initN(initN), .enN(enN), .syncMode(syncMode),
  .initWord(initWord), .dataOut(dataOut), .dataOe(dataOe)
);

// File: tb/regprom_pipe_test.sv
module regprom_pipe_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eraseN = 1'b0;
  logic        progEn = 1'b0;
  logic [1:0]  progSel = 2'd3;
  logic [10:0] progAddr = '0;
  logic [7:0]  progData = '0;
  logic [10:0] addr = '0;
  logic        initN = 1'b1;
  logic        enN = 1'b1;
  logic [7:0]  dataOut;
  logic [7:0]  dataOe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  regprom_pipe uut (
    .clk(clk), .rstN(rstN), .eraseN(eraseN), .progEn(progEn), .progSel(progSel),
    .progAddr(progAddr), .progData(progData), .addr(addr), .initN(initN),
    .enN(enN), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [1:0] sel, input logic [10:0] a, input logic [7:0] d);
    progEn = 1'b1; progSel = sel; progAddr = a; progData = d;
    step();
    progEn = 1'b0; progSel = 2'd3;
  endtask

  task automatic t_erased();
    addr = 11'd5; step();
    chk("R1 erased word", dataOut, 8'h00);
    enN = 1'b1; #1 chk("R7 async off", dataOe, 8'h00);
    enN = 1'b0; #1 chk("R7 async on without edge", dataOe, 8'hFF);
  endtask

  task automatic t_read();
    prog(2'd0, 11'd5, 8'hA5);
    prog(2'd0, 11'd5, 8'h0A);
    prog(2'd0, 11'd2047, 8'h3C);
    prog(2'd0, 11'd0, 8'h11);
    addr = 11'd5; step();
    chk("R3 bits ORed", dataOut, 8'hAF);
    addr = 11'd2047; #1;
    chk("R2 hold between edges", dataOut, 8'hAF);
    step();
    chk("R2 top address", dataOut, 8'h3C);
    addr = 11'd0; step();
    chk("R2 address zero", dataOut, 8'h11);
  endtask

  task automatic t_init_clear();
    initN = 1'b0; #1;
    chk("R6 clear with blank word", dataOut, 8'h00);
    step(); step();
    chk("R4 held across edges", dataOut, 8'h00);
    initN = 1'b1; step(); step();
    chk("R5 array after recovery", dataOut, 8'h11);
  endtask

  task automatic t_init_recover();
    prog(2'd1, 11'd0, 8'hFF);
    addr = 11'd5; step();
    chk("R2 before init", dataOut, 8'hAF);
    initN = 1'b0; #1;
    chk("R6 preset immediate", dataOut, 8'hFF);
    step();
    initN = 1'b1; step();
    chk("R5 first edge keeps init word", dataOut, 8'hFF);
    step();
    chk("R5 second edge loads array", dataOut, 8'hAF);
  endtask

  task automatic t_sync();
    prog(2'd2, 11'd0, 8'h00);
    enN = 1'b0;
    rstN = 1'b0; #1 rstN = 1'b1; #0.5;
    chk("R9 off after power-up", dataOe, 8'h00);
    step();
    chk("R8 on at edge", dataOe, 8'hFF);
    enN = 1'b1; #1;
    chk("R8 no immediate off", dataOe, 8'hFF);
    step();
    chk("R8 off at edge", dataOe, 8'h00);
    enN = 1'b0; #0.5 enN = 1'b1;
    step();
    chk("R8 glitch between edges ignored", dataOe, 8'h00);
    initN = 1'b0; #1;
    chk("R10 init keeps drive off", dataOe, 8'h00);
    chk("R4 init word while off", dataOut, 8'hFF);
    initN = 1'b1; enN = 1'b0; step();
    chk("R8 on again", dataOe, 8'hFF);
  endtask

  task automatic t_erase();
    eraseN = 1'b0; #1 eraseN = 1'b1;
    enN = 1'b1; #1;
    chk("R1 erase back to async", dataOe, 8'h00);
    addr = 11'd5; step(); step();
    chk("R1 erased after programming", dataOut, 8'h00);
    initN = 1'b0; #1;
    chk("R1 init word erased", dataOut, 8'h00);
    initN = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    eraseN = 1'b1; rstN = 1'b1;
    #1;
    chk("R9 reset async with enN high", dataOe, 8'h00);
    chk("R1 reset data", dataOut, 8'h00);
    t_erased();
    t_read();
    t_init_clear();
    t_init_recover();
    t_sync();
    t_erase();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule